// File: doc/BRIEF.md
# Byte-Lane Write Mask Generator

This block turns the write controls of a 32-bit synchronous SRAM word into a registered four-bit mask that says which byte lanes the array must update. Three kinds of control feed it: a global write that forces a full-word write, a byte-write enable that lets the four per-lane strobes through, and the four per-lane strobes themselves. All of them are active low. When neither the global write nor the byte-write enable is active, the cycle is a read and no lane is written.

A mode input selects the timing. In flow-through mode the mask follows the controls after one clock edge, in the same cycle as the address and data. In pipelined mode the controls pass through one more register stage, so the mask lines up with the data cycle that follows the address cycle. The array, the address counter and the output-enable path sit outside the block.

Top module: `byteLaneWrCtrl`

## Requirements
- R1: While `rstN` is low at a rising edge, `laneMask` is all zeros after that edge and the pipeline stage is cleared. The first pipelined result after reset therefore reads as zeros.
- R2: With `allWrN` low, the decoded mask is 4'b1111 whatever `byteWrN` and `laneWrN` are.
- R3: With `allWrN` high and `byteWrN` low, decoded mask bit i is the inverse of `laneWrN[i]`. Bit 0 is the lane holding data bits 7:0, and bit 3 is the lane holding bits 31:24.
- R4: With `allWrN` and `byteWrN` both high, the decoded mask is 4'b0000 (a read), whatever `laneWrN` is.
- R5: With `pipeMode` low at an edge, `laneMask` after that edge is the decode of the controls sampled at that same edge.
- R6: With `pipeMode` high at an edge, `laneMask` after that edge is the decode of the controls sampled one edge earlier.
- R7: The mode is taken at the edge that loads `laneMask`. On a switch from flow-through to pipelined, the first pipelined output is the decode from the previous edge, with no gap and no repeat.
- R8: `laneMask` changes only at rising clock edges and holds between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| pipeMode | input | 1 | 1 = pipelined timing, 0 = flow-through |
| allWrN | input | 1 | Global write, active low, writes all lanes |
| byteWrN | input | 1 | Byte-write enable, active low, gates the lane strobes |
| laneWrN | input | 4 | Per-lane write strobes, active low, bit i = lane i |
| laneMask | output | 4 | Registered lane write mask, active high |

## Verification
Two functions can act in the same cycle: the global-write override and the per-lane strobe decode. In pipelined mode, a second pair also shares a cycle: the value the stage register is loading and the older value the output register is taking. The bench provokes both overlaps by driving every combination of the three controls back to back in each mode, so a full-word write sits next to a masked write or a read. Each mask is judged against a decode computed in the bench from the controls one or two edges earlier, depending on the mode. Mode switches in the middle of a stream and a reset in the middle of a stream check that the stage register's contents are neither dropped nor stale.

// File: rtl/lane_wr_pkg.sv
package lane_wr_pkg;
  localparam int unsigned LANE_COUNT = 4;
  localparam int unsigned LANE_BITS  = 8;
  localparam int unsigned WORD_BITS  = LANE_COUNT * LANE_BITS;

  // Active-high strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic                  fullWr;
    logic                  byteWr;
    logic                  pipeSel;
    logic [LANE_COUNT-1:0] laneSel;
  } laneCmd_t;
endpackage

// File: rtl/lane_strobe_decode.sv
module laneStrobeDecode
  import lane_wr_pkg::*;
(
  input  logic                  pipeMode,
  input  logic                  allWrN,
  input  logic                  byteWrN,
  input  logic [LANE_COUNT-1:0] laneWrN,
  output laneCmd_t              cmd
);
  logic [LANE_COUNT-1:0] laneHit;

  for (genvar gi = 0; gi < LANE_COUNT; gi++) begin : g_lane
    assign laneHit[gi] = ~laneWrN[gi];
  end

  always_comb begin
    cmd         = '0;
    cmd.fullWr  = ~allWrN;
    cmd.byteWr  = ~byteWrN;
    cmd.pipeSel = pipeMode;
    cmd.laneSel = laneHit;
  end
endmodule

// File: rtl/lane_mask_path.sv
module laneMaskPath
  import lane_wr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  laneCmd_t              cmd,
  output logic [LANE_COUNT-1:0] laneMask
);
  logic [LANE_COUNT-1:0] merged;
  logic [LANE_COUNT-1:0] stageQ;
  logic [LANE_COUNT-1:0] maskQ;

  // Global write overrides everything; the byte enable gates the lane strobes.
  always_comb begin
    merged = '0;
    if (cmd.fullWr)      merged = '1;
    else if (cmd.byteWr) merged = cmd.laneSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ <= '0;
      maskQ  <= '0;
    end else begin
      stageQ <= merged;
      maskQ  <= cmd.pipeSel ? stageQ : merged;
    end
  end

  assign laneMask = maskQ;
endmodule

// File: rtl/byte_lane_wr_ctrl.sv
module byteLaneWrCtrl
  import lane_wr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pipeMode,
  input  logic                  allWrN,
  input  logic                  byteWrN,
  input  logic [LANE_COUNT-1:0] laneWrN,
  output logic [LANE_COUNT-1:0] laneMask
);
  laneCmd_t cmd;

  laneStrobeDecode i_decode (
    .pipeMode (pipeMode),
    .allWrN   (allWrN),
    .byteWrN  (byteWrN),
    .laneWrN  (laneWrN),
    .cmd      (cmd)
  );

  laneMaskPath i_path (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .laneMask (laneMask)
  );
endmodule

// File: rtl/byte_lane_wr_ctrl_chk.sv
module byteLaneWrCtrlChk
  import lane_wr_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  pipeMode,
  input logic                  allWrN,
  input logic                  byteWrN,
  input logic [LANE_COUNT-1:0] laneWrN,
  input logic [LANE_COUNT-1:0] laneMask
);
  logic [LANE_COUNT-1:0] refNow;
  logic [1:0]            liveEdges;

  always_comb begin
    if (allWrN == 1'b0)       refNow = {LANE_COUNT{1'b1}};
    else if (byteWrN == 1'b0) refNow = ~laneWrN;
    else                      refNow = {LANE_COUNT{1'b0}};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                liveEdges <= 2'd0;
    else if (liveEdges != 2'd3) liveEdges <= liveEdges + 2'd1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> laneMask == '0);
  // R2
  a_r2_global_all: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && !allWrN) |=> laneMask == {LANE_COUNT{1'b1}});
  // R4
  a_r4_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && allWrN && byteWrN) |=> laneMask == '0);
  // R5, R3
  a_r5_flow_match: assert property (@(posedge clk) disable iff (!rstN)
    !pipeMode |=> laneMask == $past(refNow));
  // R6, R7
  a_r6_pipe_match: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && liveEdges != 2'd0) |=> laneMask == $past(refNow, 2));
endmodule

bind byteLaneWrCtrl byteLaneWrCtrlChk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pipeMode (pipeMode),
  .allWrN   (allWrN),
  .byteWrN  (byteWrN),
  .laneWrN  (laneWrN),
  .laneMask (laneMask)
);

// File: tb/test_byteLaneWrCtrl.sv
`timescale 1ns/1ps
module test_byteLaneWrCtrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pipeMode = 1'b0;
  logic       allWrN = 1'b1;
  logic       byteWrN = 1'b1;
  logic [3:0] laneWrN = 4'hF;
  logic [3:0] laneMask;

  int checks = 0;
  int fails = 0;
  logic [3:0] prevDec = 4'h0;
  bit done = 0;

  // {pipeMode, allWrN, byteWrN, laneWrN}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_0_1_1111, 7'b0_1_0_1010, 7'b0_1_1_0000, 7'b0_1_0_0101,
    7'b0_0_0_0000, 7'b0_1_0_1110, 7'b1_1_0_0111, 7'b1_0_1_1111,
    7'b1_1_1_0000, 7'b1_1_0_1011, 7'b0_1_0_1101, 7'b1_1_0_0011
  };

  byteLaneWrCtrl i_byteLaneWrCtrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .allWrN(allWrN),
    .byteWrN(byteWrN), .laneWrN(laneWrN), .laneMask(laneMask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] decodeRef(logic a, logic b, logic [3:0] l);
    if (!a) return 4'hF;
    if (!b) return ~l;
    return 4'h0;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: laneMask=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at next falling edge.
  task automatic step(logic m, logic a, logic b, logic [3:0] l, string req);
    logic [3:0] cur;
    logic [3:0] exp;
    pipeMode = m; allWrN = a; byteWrN = b; laneWrN = l;
    cur = decodeRef(a, b, l);
    exp = m ? prevDec : cur;
    @(negedge clk);
    check(req, laneMask, exp);
    prevDec = cur;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", laneMask, 4'h0);
    rstN = 1'b1;

    // Directed vectors from the table
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0], "R2/R3/R4/R5/R6 table");

    // Exhaustive sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 64; c++) begin
        step(m[0], c[5], c[4], c[3:0], m[0] ? "R6 sweep" : "R5 sweep");
      end
    end

    // R3 lane order: only lane 0 written
    step(1'b0, 1'b1, 1'b0, 4'b1110, "R3");
    check("R3", laneMask, 4'b0001);
    // R4 read ignores all strobes
    step(1'b0, 1'b1, 1'b1, 4'b0000, "R4");
    check("R4", laneMask, 4'b0000);
    // R2 global overrides disabled byte enable
    step(1'b0, 1'b0, 1'b1, 4'b1111, "R2");
    check("R2", laneMask, 4'b1111);

    // R7: switch flow -> pipelined keeps the previous decode
    step(1'b0, 1'b1, 1'b0, 4'b1001, "R7 pre");
    step(1'b1, 1'b1, 1'b1, 4'b1111, "R7");
    check("R7", laneMask, 4'b0110);
    step(1'b0, 1'b0, 1'b1, 4'b1111, "R7 back");

    // R8: output holds between edges
    step(1'b0, 1'b1, 1'b0, 4'b0110, "R8 setup");
    #(CLK_PERIOD/4);
    allWrN = 1'b0;
    #1;
    check("R8", laneMask, 4'b1001);
    allWrN = 1'b1;
    @(negedge clk);
    prevDec = decodeRef(1'b1, 1'b0, 4'b0110);

    // R1: reset in the middle of a pipelined stream clears the stage
    step(1'b1, 1'b0, 1'b0, 4'b0000, "R1 pre");
    rstN = 1'b0;
    @(negedge clk);
    check("R1", laneMask, 4'h0);
    rstN = 1'b1;
    prevDec = 4'h0;
    step(1'b1, 1'b1, 1'b0, 4'b0011, "R1 stage cleared");
    step(1'b1, 1'b1, 1'b1, 4'b0000, "R6");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule